// File: doc/BRIEF.md
# Wide-Bus CRC-32 with Zero-Pad Rollback

This block computes the Ethernet CRC-32 of frames that arrive on a wide data bus at one word per clock. A frame occupies one or more consecutive accepted beats. The first beat is flagged as start and the last as end. On the end beat, a byte count says how many trailing byte lanes carry no frame data.

Instead of holding one update network for every possible width of the last beat, the block does the following:

- It forces the unused lanes to zero.
- It runs the padded word through the single full-width update network.
- It removes the effect of the zero bytes afterwards. A short pipeline of rollback stages does this. Each stage steps the raw CRC register backwards over a fixed power-of-two number of bytes, and it acts only when the matching bit of the padding count is set.

The final inversion is applied once the rollback is finished. The result arrives a fixed number of cycles after the end beat. A new frame may begin on the very next cycle.

Byte lane k of the bus is `in_data[8k+7:8k]`. Lane 0 is first on the wire, and each byte is taken least significant bit first.

Top module: `crc_wide_rollback`

## Requirements
- R1: While reset is held, and in the cycles after it is released before any end beat is accepted, `out_valid` is 0.
- R2: A frame of one beat (`in_start` and `in_end` both 1) is seeded and finished within that beat. The bytes "123456789" in lanes 0..8 with `in_pad` = 7 give `out_crc` = 0xCBF43926.
- R3: A frame spanning several beats gives the CRC-32 (reflected polynomial 0xEDB88320, seed 0xFFFFFFFF, final inversion) of all bytes of its full beats followed by the valid lanes of its end beat.
- R4: On the end beat, the contents of the lanes at index BYTES-`in_pad` and above have no effect on `out_crc`.
- R5: `in_pad` has no effect on any beat that is not an end beat; such beats always contribute all BYTES lanes.
- R6: Every padding count from 0 to BYTES-1 yields the CRC of exactly BYTES-`in_pad` valid lanes. A rollback stage whose padding bit is clear passes the state through unchanged.
- R7: `out_valid` rises for exactly one cycle per end beat. If an end beat is accepted at clock edge E, the result is presented after edge E+log2(BYTES), which is log2(BYTES)+1 edges counting the accepting one.
- R8: Frames may follow each other on consecutive cycles with no idle cycle; results emerge in order, one per frame.
- R9: Cycles with `in_valid` = 0 are ignored whatever `in_start`, `in_end`, `in_pad` and `in_data` carry, including in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Beat on the bus is accepted this cycle |
| in_start | input | 1 | Beat is the first of a frame |
| in_end | input | 1 | Beat is the last of a frame |
| in_pad | input | log2(DATA_W/8) | Unused trailing byte lanes on the end beat |
| in_data | input | DATA_W | Beat data, lane 0 in bits 7:0 |
| out_valid | output | 1 | One-cycle strobe, `out_crc` holds a result |
| out_crc | output | 32 | Finished CRC-32 of the frame |

## Verification
The assertions assume that every frame on the input opens with a start beat and closes with an end beat. They also assume that the accumulator state is only meaningful between those beats, and that reset is held for at least one edge before data is sent.

The stimulus keeps within these assumptions. Each frame is built as a contiguous run of valid beats, marked at both ends. Idle cycles may sit between the beats, and those cycles carry random control and data with `in_valid` low. Lanes beyond the padding and the padding field of non-end beats are filled with random junk. Any result that depends on them then shows up as a CRC mismatch against a bytewise model.

// File: rtl/crc_wide_pkg.sv
// Shared constants and single-bit CRC-32 steps (reflected form).
// Assumes the raw register is kept uninverted; inversion happens at the output.
package crc_wide_pkg;
    localparam logic [31:0] POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED  = 32'hFFFFFFFF;

    // Advance the raw register by one data bit.
    function automatic logic [31:0] crc_step_fwd(logic [31:0] c, logic d);
        return (c >> 1) ^ ((c[0] ^ d) ? POLY_REFL : 32'h0);
    endfunction

    // Undo one forward step taken with a zero data bit.
    function automatic logic [31:0] crc_step_back(logic [31:0] c);
        logic b;
        b = c[31];
        return ((c ^ (b ? POLY_REFL : 32'h0)) << 1) | {31'b0, b};
    endfunction
endpackage

// File: rtl/crc_pad_mask.sv
// Zeroes the trailing byte lanes of an end beat that the padding count marks unused.
// Assumes valid lanes are the low-indexed ones; non-end beats pass untouched.
module crc_pad_mask #(
    parameter int DATA_W = 128,
    parameter int BYTES  = DATA_W / 8,
    parameter int PAD_W  = $clog2(BYTES)
) (
    input  logic              last_i,
    input  logic [PAD_W-1:0]  pad_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o
);
    // Keep a lane when the beat is not the last or the lane lies below the pad.
    always_comb begin
        for (int k = 0; k < BYTES; k++) begin
            if (!last_i || (k < (BYTES - int'(pad_i))))
                data_o[8*k +: 8] = data_i[8*k +: 8];
            else
                data_o[8*k +: 8] = 8'h00;
        end
    end
endmodule

// File: rtl/crc_word_engine.sv
// Full-width CRC-32 update of one bus word per cycle, plus the running frame state.
// Assumes bit i of the word is the i-th bit on the wire; a start beat reseeds.
module crc_word_engine #(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_i,
    input  logic              start_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [31:0]       next_o
);
    import crc_wide_pkg::*;

    logic [31:0] acc_q;

    // Fold every bit of the word into the seed or the running state.
    always_comb begin
        next_o = start_i ? CRC_SEED : acc_q;
        for (int i = 0; i < DATA_W; i++)
            next_o = crc_step_fwd(next_o, word_i[i]);
    end

    // Hold the running state across the beats of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= CRC_SEED;
        else if (beat_i)
            acc_q <= next_o;
    end
endmodule

// File: rtl/crc_rollback_stage.sv
// One rollback stage: steps the raw state back over SHIFT_BITS zero bits
// when bit IDX of the travelling padding count is set, else passes it on.
// Assumes the state fed in was produced with zeros in the rolled-back span.
module crc_rollback_stage #(
    parameter int SHIFT_BITS = 8,
    parameter int PAD_W      = 4,
    parameter int IDX        = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic [PAD_W-1:0] pad_i,
    input  logic [31:0]      crc_i,
    output logic             vld_o,
    output logic [PAD_W-1:0] pad_o,
    output logic [31:0]      crc_o
);
    import crc_wide_pkg::*;

    logic [31:0] back;

    // Fixed reverse network over SHIFT_BITS zero bits.
    always_comb begin
        back = crc_i;
        for (int s = 0; s < SHIFT_BITS; s++)
            back = crc_step_back(back);
    end

    // Register the chosen state together with its strobe and padding count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o <= 1'b0;
            pad_o <= '0;
            crc_o <= '0;
        end else begin
            vld_o <= vld_i;
            pad_o <= pad_i;
            crc_o <= pad_i[IDX] ? back : crc_i;
        end
    end

    assert_pass_through_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !pad_i[IDX]) |=> (crc_o == $past(crc_i)));
    assert_valid_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> vld_o);
    assert_pad_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> (pad_o == $past(pad_i)));
endmodule

// File: rtl/crc_wide_rollback.sv
// Top: masks the end beat, updates the CRC over the full word, then rolls the
// raw state back through log2(BYTES) stages and inverts it at the output.
// Assumes frames are delimited by start/end beats; one beat per cycle at most.
module crc_wide_rollback #(
    parameter int DATA_W = 128,
    localparam int BYTES  = DATA_W / 8,
    localparam int PAD_W  = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_start,
    input  logic              in_end,
    input  logic [PAD_W-1:0]  in_pad,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [31:0]       out_crc
);
    localparam int STAGES = PAD_W;

    logic [DATA_W-1:0] word_m;
    logic [31:0]       word_crc;
    logic              vld_s [0:STAGES];
    logic [PAD_W-1:0]  pad_s [0:STAGES];
    logic [31:0]       crc_s [0:STAGES];

    crc_pad_mask #(.DATA_W(DATA_W), .BYTES(BYTES), .PAD_W(PAD_W)) i_mask (
        .last_i (in_end),
        .pad_i  (in_pad),
        .data_i (in_data),
        .data_o (word_m)
    );

    crc_word_engine #(.DATA_W(DATA_W)) i_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .beat_i  (in_valid),
        .start_i (in_start),
        .word_i  (word_m),
        .next_o  (word_crc)
    );

    // Capture the padded-word CRC of each end beat at the head of the pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_s[0] <= 1'b0;
            pad_s[0] <= '0;
            crc_s[0] <= '0;
        end else begin
            vld_s[0] <= in_valid && in_end;
            pad_s[0] <= in_pad;
            crc_s[0] <= word_crc;
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_roll
        crc_rollback_stage #(.SHIFT_BITS(8 << g), .PAD_W(PAD_W), .IDX(g)) i_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .vld_i (vld_s[g]),
            .pad_i (pad_s[g]),
            .crc_i (crc_s[g]),
            .vld_o (vld_s[g+1]),
            .pad_o (pad_s[g+1]),
            .crc_o (crc_s[g+1])
        );
    end

    assign out_valid = vld_s[STAGES];
    assign out_crc   = ~crc_s[STAGES];

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);
    assert_head_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_end) |=> vld_s[0]);
endmodule

// File: tb/test_crc_wide_rollback.sv
module test_crc_wide_rollback;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 128;
    localparam int BYTES  = DATA_W / 8;
    localparam int PAD_W  = $clog2(BYTES);
    localparam int STAGES = PAD_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_start = 1'b0, in_end = 1'b0;
    logic [PAD_W-1:0]  in_pad = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic out_valid;
    logic [31:0] out_crc;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    logic [31:0] exp_crc [0:511];
    int          exp_edge [0:511];
    string       exp_tag [0:511];
    int wr_i = 0, rd_i = 0;
    logic [7:0] fb [0:1023];

    crc_wide_rollback #(.DATA_W(DATA_W)) i_crc_wide_rollback (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_end(in_end), .in_pad(in_pad), .in_data(in_data),
        .out_valid(out_valid), .out_crc(out_crc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk32(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_int(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_crc(int n);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++) begin
            c ^= {24'h0, fb[i]};
            for (int b = 0; b < 8; b++)
                c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    // Output monitor: value and latency of every result (R7 on timing).
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (rd_i == wr_i) begin
                n_cmp++; n_bad++;
                $display("FAIL R7: actual strobe with crc %h expected no strobe", out_crc);
            end else begin
                chk32(exp_tag[rd_i], out_crc, exp_crc[rd_i]);
                chk_int("R7 latency", cyc, exp_edge[rd_i] + STAGES);
                rd_i++;
            end
        end
    end

    task automatic fill(int n);
        for (int i = 0; i < n; i++) fb[i] = 8'($urandom);
    endtask

    // Send fb[0..n-1] as one frame; gap inserts a junk idle cycle between beats.
    task automatic send_frame(int n, string tag, bit gap, bit use_fix, logic [31:0] fix);
        int nb = (n + BYTES - 1) / BYTES;
        for (int b = 0; b < nb; b++) begin
            @(negedge clk);
            if (gap && b > 0) begin
                in_valid = 1'b0; in_start = 1'($urandom); in_end = 1'b1;
                in_pad = PAD_W'($urandom);
                for (int k = 0; k < BYTES; k++) in_data[8*k +: 8] = 8'($urandom);
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_start = (b == 0);
            in_end   = (b == nb - 1);
            for (int k = 0; k < BYTES; k++) begin
                int idx = b * BYTES + k;
                in_data[8*k +: 8] = (idx < n) ? fb[idx] : 8'($urandom);
            end
            if (b == nb - 1) begin
                in_pad = PAD_W'(nb * BYTES - n);
                exp_crc[wr_i]  = use_fix ? fix : model_crc(n);
                exp_edge[wr_i] = cyc + 1;
                exp_tag[wr_i]  = tag;
                wr_i++;
            end else begin
                in_pad = PAD_W'($urandom);
            end
        end
    endtask

    task automatic drain(string tag);
        @(negedge clk);
        in_valid = 1'b0; in_end = 1'b0; in_start = 1'b0;
        repeat (STAGES + 3) @(negedge clk);
        chk_int(tag, rd_i, wr_i);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        in_valid = 1'b1; in_start = 1'b1; in_end = 1'b1;
        repeat (3) @(negedge clk);
        chk32("R1 during reset", {31'b0, out_valid}, 32'h0);
        rst_n = 1'b1; in_valid = 1'b0;
        for (int i = 0; i < STAGES + 2; i++) begin
            @(negedge clk);
            chk32("R1 after reset", {31'b0, out_valid}, 32'h0);
        end
    endtask

    task automatic test_known();
        for (int i = 0; i < 9; i++) fb[i] = 8'h31 + 8'(i);
        send_frame(9, "R2 check value", 1'b0, 1'b1, 32'hCBF43926);
        drain("R2 drained");
    endtask

    task automatic test_all_pads();
        for (int n = 1; n <= BYTES; n++) begin
            fill(n);
            send_frame(n, "R6 pad sweep", 1'b0, 1'b0, 32'h0);
        end
        drain("R6 drained");
    endtask

    task automatic test_multi();
        for (int n = BYTES + 1; n <= 3 * BYTES + 2; n++) begin
            fill(n);
            send_frame(n, "R3 multi-beat", 1'b0, 1'b0, 32'h0);
        end
        drain("R3 drained");
    endtask

    task automatic test_pad_junk();
        fill(21);
        for (int r = 0; r < 4; r++)
            send_frame(21, "R4 junk in pad lanes", 1'b0, 1'b0, 32'h0);
        drain("R4 drained");
    endtask

    task automatic test_nonend_pad();
        fill(64);
        send_frame(64, "R5 full beats", 1'b0, 1'b0, 32'h0);
        fill(47);
        send_frame(47, "R5 pad on middle beats", 1'b0, 1'b0, 32'h0);
        drain("R5 drained");
    endtask

    task automatic test_gaps();
        for (int n = 30; n < 38; n++) begin
            fill(n);
            send_frame(n, "R9 idle cycles inside frame", 1'b1, 1'b0, 32'h0);
        end
        drain("R9 drained");
    endtask

    task automatic test_b2b();
        for (int r = 0; r < 20; r++) begin
            int n = 1 + int'($urandom % (2 * BYTES));
            fill(n);
            send_frame(n, "R8 back-to-back", 1'b0, 1'b0, 32'h0);
        end
        drain("R8 drained");
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R7: watchdog, actual %0d cycles expected completion earlier", cyc);
        summary();
        $finish;
    end

    initial begin
        test_reset();
        test_known();
        test_all_pads();
        test_multi();
        test_pad_junk();
        test_nonend_pad();
        test_gaps();
        test_b2b();
        summary();
        $finish;
    end
endmodule